// File: doc/BRIEF.md
# Automatic Crossover Resolver for a Four-Pair Copper Port

This block picks the pair assignment of a four-pair copper port: straight (MDI) or crossed (MDI-X). It then routes the four logical pair channels (A, B, C, D) onto the four physical pairs in both directions. A two-bit mode input either forces one of the two assignments or lets the block search for the right one by itself. A resolved flag tells the auto-negotiation engine when it may start.

In the automatic mode the block holds one assignment for a fixed sample window. It watches the receive pair that the current assignment selects: physical pair 1 when straight, physical pair 0 when crossed. Either link pulses or plain signal energy on that pair count as activity, so a peer that sends link pulses and a legacy 100 Mb/s peer that only shows energy are both found. When a window ends with no activity, a bit from a free-running pseudo-random source decides whether the assignment flips or stays. Two such ports searching against each other therefore drift apart and settle. Activity on the selected pair locks the assignment. A full window without activity releases the lock and the search resumes.

Top module: `mdix_resolver`

## Requirements
- R1: With mode 2'b00 (forced straight), mdix_o is 0 and resolved_o is 1 in the same cycle the mode is applied, with no clock edge needed.
- R2: With mode 2'b01 (forced crossed), mdix_o is 1 and resolved_o is 1 in the same cycle the mode is applied.
- R3: When mdix_o is 0, physical pair p carries logical channel p in both directions. Channel 0 is A, 1 is B, 2 is C and 3 is D, and channel or pair k occupies bits [k*W +: W] of its bus.
- R4: When mdix_o is 1, pairs 0 and 1 exchange channels A and B, and pairs 2 and 3 exchange channels C and D, in both the transmit and the receive direction.
- R5: Mode values 2'b10 and 2'b11 select automatic search. After reset in automatic mode, mdix_o is 0 and resolved_o is 0.
- R6: While searching, mdix_o changes only at the end of a sample window. A window is WIN_CYCLES clock edges counted from reset release or from the most recent window end.
- R7: The flip-or-keep decision comes from an 11-bit LFSR (x^11 + x^9 + 1) that is seeded nonzero at reset and never reaches zero. Over many idle windows, both flips and holds occur.
- R8: A link pulse or energy indication on the selected receive pair raises resolved_o at the next clock edge, and mdix_o keeps its value. The selected pair is physical pair 1 when mdix_o is 0 and physical pair 0 when mdix_o is 1. Index k of link_pulse_i and energy_i refers to physical pair k.
- R9: Activity on the receive pair that is not selected does not raise resolved_o.
- R10: While locked, mdix_o is stable. resolved_o falls after exactly WIN_CYCLES consecutive edges without activity on the selected pair, and any shorter gap keeps the lock.
- R11: Against an energy-only peer that needs the crossed assignment (energy on pair 0 alone), the automatic search ends with resolved_o = 1 and mdix_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 forced straight, 01 forced crossed, 1x automatic |
| link_pulse_i | input | 2 | Link-pulse detect, index = physical pair 0/1 |
| energy_i | input | 2 | Signal/energy detect, index = physical pair 0/1 |
| chan_tx_i | input | 4*W | Logical channels A..D toward the line |
| pair_tx_o | output | 4*W | Physical pairs 0..3 toward the line |
| pair_rx_i | input | 4*W | Physical pairs 0..3 from the line |
| chan_rx_o | output | 4*W | Logical channels A..D from the line |
| mdix_o | output | 1 | Resolved assignment, 1 = crossed |
| resolved_o | output | 1 | Assignment settled; auto-negotiation may start |

## Verification
The data words that go through the steering use a distinct value on every channel, so any missing swap or wrong swap shows up. They are applied under both forced modes and then again after an automatic lock onto the crossed assignment. In the idle automatic search, the edge of each assignment change is recorded; this separates boundary-aligned flips from flips in mid-window and shows whether the random source gives both outcomes. Activity is applied in four ways: link pulses on the selected pair, pulses on the wrong pair, energy only on pair 0, and gaps one edge shorter than a window and exactly a window long. These show apart lock acquisition, rejection of the wrong pair, the energy fallback and the release timing.

// File: rtl/mdix_pkg.sv
package mdix_pkg;
  localparam int PAIRS    = 4;
  localparam int LFSR_W   = 11;
  localparam int LFSR_TAP = 8;  // x^11 + x^9 + 1
  localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } res_state_e;
endpackage

// File: rtl/mdix_lfsr.sv
module mdix_lfsr
  import mdix_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic bit_o
);
  logic [LFSR_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= LFSR_SEED;
    else         q <= {q[LFSR_W-2:0], q[LFSR_W-1] ^ q[LFSR_TAP]};
  end

  assign bit_o = q[0];

  p_lfsr_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0);
endmodule

// File: rtl/mdix_search_fsm.sv
module mdix_search_fsm
  import mdix_pkg::*;
#(
  parameter int WIN_CYCLES = 7_750_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       auto_i,
  input  logic       force_mdix_i,
  input  logic       rand_bit_i,
  input  logic [1:0] rx_act_i,
  output logic       mdix_o,
  output logic       locked_o
);
  localparam int CNT_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

  res_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdix_q, mdix_d;
  logic             act, win_end;

  // straight listens on pair 1, crossed on pair 0
  assign act     = mdix_q ? rx_act_i[0] : rx_act_i[1];
  assign win_end = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mdix_d  = mdix_q;
    if (!auto_i) begin
      state_d = ST_SEARCH;
      cnt_d   = '0;
      mdix_d  = force_mdix_i;
    end else if (act) begin
      state_d = ST_LOCKED;
      cnt_d   = '0;
    end else if (win_end) begin
      cnt_d = '0;
      if (state_q == ST_LOCKED) state_d = ST_SEARCH;
      else if (rand_bit_i)      mdix_d  = ~mdix_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEARCH;
      cnt_q   <= '0;
      mdix_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mdix_q  <= mdix_d;
    end
  end

  assign mdix_o   = mdix_q;
  assign locked_o = (state_q == ST_LOCKED);

  p_forced_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_i |=> mdix_q == $past(force_mdix_i));
  p_search_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && state_q == ST_SEARCH && !win_end) |=> $stable(mdix_q));
  p_activity_locks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && act) |=> state_q == ST_LOCKED);
  p_lock_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && state_q == ST_LOCKED) |=> $stable(mdix_q));
  p_lock_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && state_q == ST_LOCKED && !act && !win_end) |=> state_q == ST_LOCKED);
endmodule

// File: rtl/mdix_pair_steer.sv
module mdix_pair_steer
  import mdix_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             cross_i,
  input  logic [PAIRS*W-1:0] chan_tx_i,
  output logic [PAIRS*W-1:0] pair_tx_o,
  input  logic [PAIRS*W-1:0] pair_rx_i,
  output logic [PAIRS*W-1:0] chan_rx_o
);
  // crossing swaps neighbours 0<->1 and 2<->3, so the map is its own inverse
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int MATE = p ^ 1;
    assign pair_tx_o[p*W +: W] = cross_i ? chan_tx_i[MATE*W +: W] : chan_tx_i[p*W +: W];
    assign chan_rx_o[p*W +: W] = cross_i ? pair_rx_i[MATE*W +: W] : pair_rx_i[p*W +: W];
  end
endmodule

// File: rtl/mdix_resolver.sv
module mdix_resolver
  import mdix_pkg::*;
#(
  parameter int W          = 8,
  parameter int WIN_CYCLES = 7_750_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [1:0]         link_pulse_i,
  input  logic [1:0]         energy_i,
  input  logic [4*W-1:0]     chan_tx_i,
  output logic [4*W-1:0]     pair_tx_o,
  input  logic [4*W-1:0]     pair_rx_i,
  output logic [4*W-1:0]     chan_rx_o,
  output logic               mdix_o,
  output logic               resolved_o
);
  logic auto_en, rand_bit, fsm_mdix, fsm_locked;

  assign auto_en = mode_i[1];

  mdix_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_o  (rand_bit)
  );

  mdix_search_fsm #(.WIN_CYCLES(WIN_CYCLES)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .auto_i       (auto_en),
    .force_mdix_i (mode_i[0]),
    .rand_bit_i   (rand_bit),
    .rx_act_i     (link_pulse_i | energy_i),
    .mdix_o       (fsm_mdix),
    .locked_o     (fsm_locked)
  );

  // forced modes bypass the registers so auto-negotiation is never delayed
  assign mdix_o     = auto_en ? fsm_mdix : mode_i[0];
  assign resolved_o = ~auto_en | fsm_locked;

  mdix_pair_steer #(.W(W)) u_steer (
    .cross_i   (mdix_o),
    .chan_tx_i (chan_tx_i),
    .pair_tx_o (pair_tx_o),
    .pair_rx_i (pair_rx_i),
    .chan_rx_o (chan_rx_o)
  );
endmodule

// File: tb/sim_mdix_resolver.sv
module sim_mdix_resolver;
  localparam int W   = 4;
  localparam int WIN = 32;
  localparam int NV  = 6;
  // {mode, data in, steered data, mdix, resolved}
  localparam logic [35:0] VEC [NV] = '{
    {2'b00, 16'h4321, 16'h4321, 1'b0, 1'b1},
    {2'b01, 16'h4321, 16'h3412, 1'b1, 1'b1},
    {2'b00, 16'hBEEF, 16'hBEEF, 1'b0, 1'b1},
    {2'b01, 16'hBEEF, 16'hEBFE, 1'b1, 1'b1},
    {2'b01, 16'h0F0F, 16'hF0F0, 1'b1, 1'b1},
    {2'b00, 16'h0F0F, 16'h0F0F, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b10, lp = 2'b00, en = 2'b00;
  logic [15:0] ctx = '0, prx = '0;
  logic [15:0] ptx, crx;
  logic mdix, res;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mdix_resolver #(.W(W), .WIN_CYCLES(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .link_pulse_i(lp), .energy_i(en),
    .chan_tx_i(ctx), .pair_tx_o(ptx), .pair_rx_i(prx), .chan_rx_o(crx),
    .mdix_o(mdix), .resolved_o(res)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lp = '0; en = '0; mode = 2'b10;
    #9; rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int toggles, bad_pos, bad, n;
    logic prev;
    #3;
    // R5: reset state in automatic mode
    check("R5 mdix in reset", 32'(mdix), 0);
    check("R5 resolved in reset", 32'(res), 0);
    do_reset();
    step();
    check("R5 mdix after reset", 32'(mdix), 0);
    check("R5 resolved after reset", 32'(res), 0);

    // forced modes and steering, combinational
    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][35:34]; ctx = VEC[i][33:18]; prx = VEC[i][33:18];
      #1;
      check(mode[0] ? "R2 mdix" : "R1 mdix", 32'(mdix), 32'(VEC[i][1]));
      check(mode[0] ? "R2 resolved" : "R1 resolved", 32'(res), 32'(VEC[i][0]));
      check(mode[0] ? "R4 tx steer" : "R3 tx steer", 32'(ptx), 32'(VEC[i][17:2]));
      check(mode[0] ? "R4 rx steer" : "R3 rx steer", 32'(crx), 32'(VEC[i][17:2]));
    end

    // R6/R7: idle search, changes only on window boundaries, both outcomes
    do_reset();
    prev = 1'b0; toggles = 0; bad_pos = 0;
    for (int e = 1; e <= 60 * WIN; e++) begin
      step();
      if (mdix !== prev) begin
        toggles++;
        if (e % WIN != 0) bad_pos++;
        prev = mdix;
      end
    end
    check("R6 changes off boundary", 32'(bad_pos), 0);
    check("R7 some flips", 32'(toggles > 0), 1);
    check("R7 some holds", 32'(toggles < 60), 1);
    check("R6 still unresolved", 32'(res), 0);

    // R9: pulses on the non-selected pair 0 while straight, inside window 1
    do_reset();
    bad = 0;
    lp = 2'b01;
    for (int e = 1; e < WIN - 2; e++) begin
      step();
      if (res !== 1'b0) bad++;
    end
    lp = 2'b00;
    check("R9 wrong pair ignored", 32'(bad), 0);

    // R8: single link pulse on selected pair 1 locks at next edge
    do_reset();
    step(); step();
    check("R8 before pulse", 32'(res), 0);
    lp = 2'b10;
    step();
    lp = 2'b00;
    check("R8 resolved after pulse", 32'(res), 1);
    check("R8 mdix kept", 32'(mdix), 0);
    // R10: pulses with gaps shorter than a window hold the lock
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      for (int c = 0; c < 20; c++) begin
        step();
        if (res !== 1'b1 || mdix !== 1'b0) bad++;
      end
      lp = 2'b10; step(); lp = 2'b00;
    end
    check("R10 short gaps keep lock", 32'(bad), 0);

    // R11: energy-only peer on pair 0, search must end crossed
    do_reset();
    en = 2'b01;
    bad = 0; n = 0;
    while (res !== 1'b1 && n < 80 * WIN) begin
      step(); n++;
      if (mdix === 1'b0 && res === 1'b1) bad++;
    end
    check("R9 no lock while straight", 32'(bad), 0);
    check("R11 resolved", 32'(res), 1);
    check("R11 crossed", 32'(mdix), 1);
    ctx = 16'h4321; prx = 16'h8765; #1;
    check("R4 tx steer auto", 32'(ptx), 32'h3412);
    check("R4 rx steer auto", 32'(crx), 32'h7856);

    // R10: hold, then release timing
    bad = 0;
    for (int c = 0; c < 100; c++) begin
      step();
      if (res !== 1'b1 || mdix !== 1'b1) bad++;
    end
    check("R10 lock stable", 32'(bad), 0);
    en = 2'b00;
    for (int c = 0; c < WIN - 1; c++) step();
    check("R10 held one short of window", 32'(res), 1);
    en = 2'b01; step(); en = 2'b00;
    for (int c = 0; c < WIN - 1; c++) step();
    check("R10 held after refresh", 32'(res), 1);
    step();
    check("R10 released after full window", 32'(res), 0);
    check("R10 mdix kept on release", 32'(mdix), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule